// File: doc/BRIEF.md
# GPIO Interrupt Source Router

This block connects eight interrupt channels to a parent interrupt controller. Each channel picks one pin out of a wide bank of general-purpose inputs. It brings that pin into the local clock domain and can reject short glitches. It then drives its own output line, either as a level or as a one-clock pulse on a chosen transition.

Software configures the block through four word registers on a simple valid/write/address/data bus:

| Offset | Contents |
|--------|----------|
| 0x00 | Per-channel trigger mode and polarity |
| 0x04 | Pin index for channels 0 to 3 |
| 0x08 | Pin index for channels 4 to 7 |
| 0x0C | Per-channel glitch-filter length |

A channel responds to only one edge direction. To catch both edges of a pin, software points two channels at that pin and gives them opposite polarity.

Any write to a register that holds a channel's fields sets that channel to a quiet settling state. This prevents a stale history from producing a false interrupt after the configuration changes.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, `irqOut` is all zero. Reads return 0x00000000 at offset 0x00, 0xFFFFFFFF at offsets 0x04 and 0x08, and 0x00000000 at offset 0x0C.
- R2: A read with `busValid`=1 and `busWrite`=0 returns its data on `busRdata` one clock later. Bits without storage read as zero. `busRdata` is zero in any cycle that does not follow a read. The register is chosen by `busAddr[3:2]`.
- R3: Offset 0x00 holds the trigger mode of channel x in bit x (1 = edge, 0 = level) and its polarity in bit 16+x (1 = low/falling, 0 = high/rising). Offset 0x04 holds the 8-bit pin index of channel x (x = 0 to 3) in bits 8x+7:8x. Offset 0x08 holds the pin index of channel x (x = 4 to 7) in bits 8(x-4)+7:8(x-4). Offset 0x0C holds the 3-bit filter value of channel x in bits 4x+2:4x.
- R4: A channel whose index is 255, or whose index is at or above `NUM_GPIO`, keeps its output at 0 whatever its mode, polarity or pin activity.
- R5: With the filter off, a pin change driven before a rising edge reaches `irqOut` after the third rising edge. It is not visible after the second.
- R6: In level mode, the output equals the synchronised pin level XOR the polarity bit.
- R7: In edge mode, the output is high for exactly one clock after a rising transition (polarity 0) or a falling transition (polarity 1) of the synchronised pin.
- R8: Two edge-mode channels that select the same pin with opposite polarity together signal both edges of that pin, each channel firing only on its own edge.
- R9: With filter value N (1 to 7), the detector sees a new pin level only after the synchronised pin has differed from the accepted level for N×4 consecutive clocks. A shorter glitch has no effect at the output. N = 0 bypasses the filter.
- R10: A write to any register holding a channel's fields forces that channel's output to 0 at that write and for the next three clocks. Detection then restarts from the current level without a false edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Bus access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one clock after the read |
| gpioIn | input | NUM_GPIO | GPIO pin bank (default 133) |
| irqOut | output | 8 | One interrupt line per channel |

## Verification
A random phase repeatedly reprograms all eight channels with mixed modes, polarities, filters, in-range, out-of-range and unassigned indices. It then toggles the whole pin bank sparsely. A cycle-level reference model compares every output on every clock.

Directed patterns cover the following:
- A single pin held high while the other pins stay low tells a correct field packing apart from a swapped channel.
- A latency probe tells the two-stage synchroniser apart from one stage too many or too few.
- A short glitch against a filtered channel tells counted filtering apart from pass-through.
- A paired rise/fall on one pin tells polarity apart from edge direction.
- Rewriting an unchanged configuration tells the settling window apart from a missing history reset.

// File: rtl/girq_pkg.sv
package girq_pkg;
  localparam int CH_NUM     = 8;
  localparam int SRC_W      = 8;
  localparam int FILT_W     = 3;
  localparam int DATA_W     = 32;
  localparam logic [SRC_W-1:0] SRC_NONE = 8'hFF;

  typedef struct packed {
    logic              edgeMode;
    logic              activeLow;
    logic [SRC_W-1:0]  srcIdx;
    logic [FILT_W-1:0] filtSel;
  } chCfg_t;

  typedef struct packed {
    logic [CH_NUM-1:0] cfgTouch;
  } ctlStrobe_t;
endpackage

// File: rtl/girq_regs.sv
module girq_regs
  import girq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busValid,
  input  logic                     busWrite,
  input  logic [3:0]               busAddr,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  output chCfg_t [CH_NUM-1:0]      cfgVec,
  output ctlStrobe_t               strobe
);
  localparam int HALF = CH_NUM / 2;

  logic [CH_NUM-1:0]             edgeBits, polBits;
  logic [CH_NUM-1:0][SRC_W-1:0]  srcF;
  logic [CH_NUM-1:0][FILT_W-1:0] filtF;
  logic [DATA_W-1:0]             readMux;
  logic [1:0]                    regSel;
  logic                          wrEn, rdEn;

  assign regSel = busAddr[3:2];
  assign wrEn   = busValid & busWrite;
  assign rdEn   = busValid & ~busWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeBits <= '0;
      polBits  <= '0;
      srcF     <= {CH_NUM{SRC_NONE}};
      filtF    <= '0;
    end else if (wrEn) begin
      case (regSel)
        2'd0: begin
          edgeBits <= busWdata[CH_NUM-1:0];
          polBits  <= busWdata[16 +: CH_NUM];
        end
        2'd1: for (int c = 0; c < HALF; c++) srcF[c]        <= busWdata[c*SRC_W +: SRC_W];
        2'd2: for (int c = 0; c < HALF; c++) srcF[c + HALF] <= busWdata[c*SRC_W +: SRC_W];
        default: for (int c = 0; c < CH_NUM; c++) filtF[c]  <= busWdata[c*4 +: FILT_W];
      endcase
    end
  end

  always_comb begin
    readMux = '0;
    case (regSel)
      2'd0: begin
        readMux[CH_NUM-1:0]  = edgeBits;
        readMux[16 +: CH_NUM] = polBits;
      end
      2'd1: for (int c = 0; c < HALF; c++) readMux[c*SRC_W +: SRC_W] = srcF[c];
      2'd2: for (int c = 0; c < HALF; c++) readMux[c*SRC_W +: SRC_W] = srcF[c + HALF];
      default: for (int c = 0; c < CH_NUM; c++) readMux[c*4 +: FILT_W] = filtF[c];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busRdata <= '0;
    else if (rdEn) busRdata <= readMux;
    else           busRdata <= '0;
  end

  for (genvar g = 0; g < CH_NUM; g++) begin : g_cfg
    localparam logic [1:0] SRC_REG = (g < HALF) ? 2'd1 : 2'd2;
    assign cfgVec[g].edgeMode  = edgeBits[g];
    assign cfgVec[g].activeLow = polBits[g];
    assign cfgVec[g].srcIdx    = srcF[g];
    assign cfgVec[g].filtSel   = filtF[g];
    assign strobe.cfgTouch[g]  = wrEn && (regSel == 2'd0 || regSel == 2'd3 || regSel == SRC_REG);
  end
endmodule

// File: rtl/girq_channel.sv
module girq_channel
  import girq_pkg::*;
#(
  parameter int NUM_GPIO  = 133,
  parameter int FILT_UNIT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_GPIO-1:0] gpioIn,
  input  chCfg_t              cfg,
  input  logic                cfgTouch,
  output logic                irqOut
);
  localparam int MAX_FILT = (1 << FILT_W) - 1;
  localparam int CNT_W    = $clog2(MAX_FILT * FILT_UNIT);

  logic             selBit, selValid;
  logic [1:0]       syncQ;
  logic             filtLevel, prevLvl, irqQ;
  logic [CNT_W-1:0] filtCnt, filtLimit;
  logic [1:0]       holdCnt;
  logic             effLvl, polLvl, settling;

  always_comb begin
    selBit = 1'b0;
    for (int i = 0; i < NUM_GPIO; i++)
      if (int'(cfg.srcIdx) == i) selBit = gpioIn[i];
  end

  assign selValid  = (cfg.srcIdx != SRC_NONE) && (int'(cfg.srcIdx) < NUM_GPIO);
  assign filtLimit = CNT_W'(int'(cfg.filtSel) * FILT_UNIT - 1);
  assign effLvl    = (cfg.filtSel == '0) ? syncQ[1] : filtLevel;
  assign polLvl    = effLvl ^ cfg.activeLow;
  assign settling  = cfgTouch || (holdCnt != 2'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= '0;
      filtLevel <= 1'b0;
      filtCnt   <= '0;
      holdCnt   <= '0;
      prevLvl   <= 1'b0;
      irqQ      <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], selBit};
      if (settling) begin
        holdCnt   <= cfgTouch ? 2'd3 : holdCnt - 2'd1;
        filtLevel <= syncQ[1];
        filtCnt   <= '0;
        prevLvl   <= polLvl;
        irqQ      <= 1'b0;
      end else begin
        if (cfg.filtSel == '0 || syncQ[1] == filtLevel) begin
          filtLevel <= syncQ[1];
          filtCnt   <= '0;
        end else if (filtCnt == filtLimit) begin
          filtLevel <= syncQ[1];
          filtCnt   <= '0;
        end else begin
          filtCnt <= filtCnt + 1'b1;
        end
        prevLvl <= polLvl;
        irqQ    <= selValid & (cfg.edgeMode ? (polLvl & ~prevLvl) : polLvl);
      end
    end
  end

  assign irqOut = irqQ;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import girq_pkg::*;
#(
  parameter int NUM_GPIO  = 133,
  parameter int FILT_UNIT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [3:0]          busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_GPIO-1:0] gpioIn,
  output logic [7:0]          irqOut
);
  chCfg_t [CH_NUM-1:0] cfgVec;
  ctlStrobe_t          ctlStb;

  girq_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .cfgVec   (cfgVec),
    .strobe   (ctlStb)
  );

  for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
    girq_channel #(.NUM_GPIO(NUM_GPIO), .FILT_UNIT(FILT_UNIT)) u_ch (
      .clk      (clk),
      .rstN     (rstN),
      .gpioIn   (gpioIn),
      .cfg      (cfgVec[g]),
      .cfgTouch (ctlStb.cfgTouch[g]),
      .irqOut   (irqOut[g])
    );
  end
endmodule

// File: rtl/girq_checker.sv
module girq_checker
  import girq_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                busValid,
  input logic                busWrite,
  input logic [31:0]         busRdata,
  input logic [7:0]          irqOut,
  input chCfg_t [CH_NUM-1:0] cfgVec,
  input ctlStrobe_t          ctlStb
);
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |=> (busRdata == 32'h0)); // R2

  for (genvar g = 0; g < CH_NUM; g++) begin : g_chk
    AST_UNASSIGNED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (cfgVec[g].srcIdx == SRC_NONE) |=> !irqOut[g]); // R4
    AST_EDGE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      (cfgVec[g].edgeMode && irqOut[g]) |=> !irqOut[g]); // R7
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      ctlStb.cfgTouch[g] |=> !irqOut[g]); // R10
  end
endmodule

bind gpio_irq_router girq_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busWrite (busWrite),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .cfgVec   (cfgVec),
  .ctlStb   (ctlStb)
);

// File: tb/tb_gpio_irq_router.sv
module tb_gpio_irq_router;
  localparam int NG = 133;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busValid = 1'b0, busWrite = 1'b0;
  logic [3:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NG-1:0] gpioIn = '0;
  logic [7:0]    irqOut;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_router #(.NUM_GPIO(NG), .FILT_UNIT(4)) dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .gpioIn(gpioIn), .irqOut(irqOut)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---- reference model, built from the requirements ----
  logic [7:0] mEdge, mPol, mS1, mS2, mFl, mPrev, mOut;
  int mSrc[8], mFilt[8], mCnt[8], mHold[8];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mEdge <= '0; mPol <= '0; mS1 <= '0; mS2 <= '0;
      mFl <= '0; mPrev <= '0; mOut <= '0;
      for (int c = 0; c < 8; c++) begin
        mSrc[c] <= 255; mFilt[c] <= 0; mCnt[c] <= 0; mHold[c] <= 0;
      end
    end else begin : mdl
      bit wr, touch, pin, eff, p, ok;
      int sel;
      wr  = busValid && busWrite;
      sel = int'(busAddr[3:2]);
      for (int c = 0; c < 8; c++) begin
        touch = wr && (sel == 0 || sel == 3 || (sel == 1 && c < 4) || (sel == 2 && c >= 4));
        ok    = (mSrc[c] < NG);
        pin   = ok ? gpioIn[mSrc[c]] : 1'b0;
        eff   = (mFilt[c] == 0) ? mS2[c] : mFl[c];
        p     = eff ^ mPol[c];
        mS1[c] <= pin;
        mS2[c] <= mS1[c];
        if (touch || mHold[c] > 0) begin
          mHold[c] <= touch ? 3 : mHold[c] - 1;
          mFl[c] <= mS2[c]; mCnt[c] <= 0; mPrev[c] <= p; mOut[c] <= 1'b0;
        end else begin
          if (mFilt[c] == 0 || mS2[c] == mFl[c]) begin
            mFl[c] <= mS2[c]; mCnt[c] <= 0;
          end else if (mCnt[c] == mFilt[c] * 4 - 1) begin
            mFl[c] <= mS2[c]; mCnt[c] <= 0;
          end else mCnt[c] <= mCnt[c] + 1;
          mPrev[c] <= p;
          mOut[c]  <= ok & (mEdge[c] ? (p & ~mPrev[c]) : p);
        end
      end
      if (wr) begin
        case (sel)
          0: begin mEdge <= busWdata[7:0]; mPol <= busWdata[23:16]; end
          1: for (int c = 0; c < 4; c++) mSrc[c]     <= int'(busWdata[c*8 +: 8]);
          2: for (int c = 0; c < 4; c++) mSrc[c + 4] <= int'(busWdata[c*8 +: 8]);
          default: for (int c = 0; c < 8; c++) mFilt[c] <= int'(busWdata[c*4 +: 3]);
        endcase
      end
    end
  end

  bit modelOn = 0;
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      for (int c = 0; c < 8; c++) begin
        string tag;
        if (mSrc[c] >= NG)      tag = "R4 model";
        else if (mFilt[c] != 0) tag = "R9 model";
        else if (mEdge[c])      tag = "R7 model";
        else                    tag = "R6 model";
        chk(tag, {31'b0, irqOut[c]}, {31'b0, mOut[c]});
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a;
    @(negedge clk);
    busValid = 0;
    d = busRdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pickSrc();
    int r = $urandom % 10;
    if (r == 0) return 8'hFF;
    if (r == 1) return 8'(NG + $urandom % 100);
    return 8'($urandom % NG);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1234_5678));
    idle(3);
    rstN = 1;
    idle(1);
    chk("R1 irq at reset", {24'b0, irqOut}, 32'h0);
    rd(4'h0, d); chk("R1 edge/pol reset", d, 32'h0000_0000);
    rd(4'h4, d); chk("R1 src lo reset", d, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R1 src hi reset", d, 32'hFFFF_FFFF);
    rd(4'hC, d); chk("R1 filter reset", d, 32'h0000_0000);
    idle(1);
    chk("R2 rdata idle", busRdata, 32'h0);
    modelOn = 1;

    // R2: unused bits read zero
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, d); chk("R2 edge/pol bits", d, 32'h00FF_00FF);
    wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, d); chk("R2 filter bits", d, 32'h7777_7777);
    wr(4'h0, 32'h0); wr(4'hC, 32'h0);

    // R3: channel 5 selects pin 3, level, active-high
    wr(4'h4, 32'hFFFF_FFFF); wr(4'h8, 32'hFFFF_03FF);
    rd(4'h8, d); chk("R3 src hi readback", d, 32'hFFFF_03FF);
    gpioIn[3] = 1; idle(8);
    chk("R3 ch5 routes pin 3", {24'b0, irqOut}, 32'h0000_0020);

    // R6: active-low level on ch5
    wr(4'h0, 32'h0020_0000); idle(8);
    chk("R6 active-low high pin", {24'b0, irqOut}, 32'h0);
    gpioIn[3] = 0; idle(4);
    chk("R6 active-low low pin", {24'b0, irqOut}, 32'h0000_0020);

    // R5: latency with active-high level
    wr(4'h0, 32'h0); idle(8);
    gpioIn[3] = 1;
    idle(2); chk("R5 not after 2nd edge", {31'b0, irqOut[5]}, 32'h0);
    idle(1); chk("R5 after 3rd edge", {31'b0, irqOut[5]}, 32'h1);

    // R10: rewrite same config -> 4 quiet cycles, then level again
    wr(4'h0, 32'h0);
    chk("R10 quiet at write", {31'b0, irqOut[5]}, 32'h0);
    for (int k = 0; k < 3; k++) begin
      idle(1); chk("R10 quiet window", {31'b0, irqOut[5]}, 32'h0);
    end
    idle(1); chk("R10 resumes", {31'b0, irqOut[5]}, 32'h1);

    // R4: out-of-range and unassigned with active-low level must stay quiet
    wr(4'h8, 32'hFFFF_C8FF); wr(4'h0, 32'h00FF_0000); gpioIn = '0;
    idle(8);
    chk("R4 index 200 and 255 quiet", {24'b0, irqOut}, 32'h0);

    // R8: ch0 rising, ch1 falling on pin 9
    wr(4'h8, 32'hFFFF_FFFF); wr(4'h4, 32'hFFFF_0909); wr(4'h0, 32'h0002_0003);
    idle(8);
    gpioIn[9] = 1;
    idle(3); chk("R8 rise fires ch0 only", {30'b0, irqOut[1:0]}, 32'h1);
    idle(1); chk("R7 pulse one clock", {30'b0, irqOut[1:0]}, 32'h0);
    idle(4);
    gpioIn[9] = 0;
    idle(3); chk("R8 fall fires ch1 only", {30'b0, irqOut[1:0]}, 32'h2);
    idle(1); chk("R7 fall pulse one clock", {30'b0, irqOut[1:0]}, 32'h0);

    // R9: filter 1 (4 clocks), 2-clock glitch ignored, long pulse passes
    wr(4'hC, 32'h0000_0001); wr(4'h0, 32'h0); idle(8);
    gpioIn[9] = 1; idle(2); gpioIn[9] = 0;
    begin
      logic seen = 0;
      for (int k = 0; k < 12; k++) begin idle(1); seen |= irqOut[0]; end
      chk("R9 glitch rejected", {31'b0, seen}, 32'h0);
    end
    gpioIn[9] = 1;
    idle(6); chk("R9 held below window", {31'b0, irqOut[0]}, 32'h0);
    idle(1); chk("R9 passes after window", {31'b0, irqOut[0]}, 32'h1);

    // random phase
    for (int r = 0; r < 40; r++) begin
      logic [31:0] f = '0;
      wr(4'h0, $urandom);
      wr(4'h4, {pickSrc(), pickSrc(), pickSrc(), pickSrc()});
      wr(4'h8, {pickSrc(), pickSrc(), pickSrc(), pickSrc()});
      for (int c = 0; c < 8; c++)
        f[c*4 +: 3] = (($urandom % 3) == 0) ? 3'($urandom % 3) : 3'd0;
      wr(4'hC, f);
      for (int t = 0; t < 80; t++) begin
        @(negedge clk);
        for (int i = 0; i < NG; i++)
          if (($urandom % 16) == 0) gpioIn[i] = ~gpioIn[i];
      end
    end

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule